// File: doc/BRIEF.md
# Predicated Vector Element Writeback

This block sits at the end of a 512-bit vector pipeline. It merges the raw result of an operation with the old destination value under a per-element predicate. The element size sets how many predicate bits are used. Each result byte lane is taken from the new result, from the old destination, or forced to zero.

For stores it turns the same predicate into one write enable per byte lane. It also folds the per-lane exception and memory-fault indications into two summary flags. Lanes whose element is masked off never contribute to those flags.

A predicate selector of zero means that no mask register is named. In that case every element is active. Zeroing is refused for memory destinations and for operations that demand a real predicate; such a request is flagged as illegal and writes nothing. All outputs are registered, one cycle behind the input strobe.

Top module: `vec_pred_wb`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high. While `in_valid` is low, every data and flag output keeps the value it last captured.
- R2: The size code selects the element width: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. Element i covers byte lanes i*W/8 up to (i+1)*W/8-1 and is governed by `mask_reg` bit i. Mask bits above the element count (for example bits 63:8 at 64-bit size) have no effect.
- R3: With `zero_mode` = 0, each byte of an inactive element in `dest_out` equals the matching byte of `old_dest`. Bytes of active elements equal `result`.
- R4: With `zero_mode` = 1 on a legal register-destination operation, each byte of an inactive element in `dest_out` is zero.
- R5: When `pred_sel` is 0, `mask_reg` is ignored and all elements are active.
- R6: `exc_flag` is the OR of `exc_lane` bits taken over active lanes only.
- R7: When `dest_is_mem` is 1, `byte_we` has a 1 for every lane of an active element and a 0 for every other lane. When `dest_is_mem` is 0, `byte_we` is all zero. `fault_flag` is the OR of `fault_lane` bits over active lanes only.
- R8: `zero_mode` = 1 together with `dest_is_mem` = 1 or `req_pred` = 1 is illegal. For that operation `illegal_mode` reads 1, `byte_we` is zero, both flags are zero and `dest_out` equals `old_dest`. Otherwise `illegal_mode` reads 0.
- R9: During reset `out_valid`, `illegal_mode`, `exc_flag`, `fault_flag`, `byte_we` and `dest_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation strobe |
| esize | input | 2 | Element size code |
| pred_sel | input | 3 | Predicate selector; 0 means implicit all-ones |
| mask_reg | input | 64 | Contents of the selected mask register |
| zero_mode | input | 1 | 1 = zeroing, 0 = merging |
| dest_is_mem | input | 1 | Destination is memory (store) |
| req_pred | input | 1 | Operation class demands a real predicate |
| result | input | 512 | New result vector |
| old_dest | input | 512 | Prior destination vector |
| exc_lane | input | 64 | Per-byte-lane exception indications |
| fault_lane | input | 64 | Per-byte-lane memory-fault indications |
| out_valid | output | 1 | Output strobe |
| dest_out | output | 512 | Final destination vector |
| byte_we | output | 64 | Per-byte-lane store enables |
| exc_flag | output | 1 | Exception summary over active lanes |
| fault_flag | output | 1 | Fault summary over active lanes |
| illegal_mode | output | 1 | Forbidden zeroing request |

## Verification
Each result is due one rising edge after its operation is presented. Every output is captured by one register stage, so nothing takes longer. The bench drives each operation on a falling edge and drops the strobe on the next falling edge. It compares all outputs there, half a period after the capturing edge. The hold test leaves the strobe low for two further cycles and compares again at the same phase. This confirms that the captured values do not move.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'b00,
    ESZ_B16 = 2'b01,
    ESZ_B32 = 2'b10,
    ESZ_B64 = 2'b11
  } esz_e;
endpackage

// File: rtl/vpw_lane_act.sv
// Expands the element predicate into one activity bit per byte lane.
module vpw_lane_act
  import vpw_pkg::*;
#(
  parameter int unsigned NLANES = 64,
  parameter int unsigned MASK_W = 64
) (
  input  esz_e              esize,
  input  logic [MASK_W-1:0] mask_eff,
  output logic [NLANES-1:0] lane_act
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int unsigned I8  = g;
    localparam int unsigned I16 = g / 2;
    localparam int unsigned I32 = g / 4;
    localparam int unsigned I64 = g / 8;
    logic act;
    always_comb begin
      unique case (esize)
        ESZ_B8:  act = mask_eff[I8];
        ESZ_B16: act = mask_eff[I16];
        ESZ_B32: act = mask_eff[I32];
        default: act = mask_eff[I64];
      endcase
    end
    assign lane_act[g] = act;
  end
endmodule

// File: rtl/vpw_byte_sel.sv
// Per-lane choice between new result, old value and zero.
module vpw_byte_sel #(
  parameter int unsigned LW     = 8,
  parameter int unsigned NLANES = 64,
  localparam int unsigned VW    = LW * NLANES
) (
  input  logic [VW-1:0]     result,
  input  logic [VW-1:0]     old_dest,
  input  logic [NLANES-1:0] lane_use,
  input  logic              zero_en,
  output logic [VW-1:0]     dest_nxt
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LW-1:0] b;
    always_comb begin
      if (lane_use[g])  b = result[g*LW +: LW];
      else if (zero_en) b = '0;
      else              b = old_dest[g*LW +: LW];
    end
    assign dest_nxt[g*LW +: LW] = b;
  end
endmodule

// File: rtl/vec_pred_wb.sv
module vec_pred_wb
  import vpw_pkg::*;
#(
  parameter int unsigned NLANES = 64,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned VW     = NLANES * LANE_W,
  localparam int unsigned MASK_W = NLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        esize,
  input  logic [SEL_W-1:0]  pred_sel,
  input  logic [MASK_W-1:0] mask_reg,
  input  logic              zero_mode,
  input  logic              dest_is_mem,
  input  logic              req_pred,
  input  logic [VW-1:0]     result,
  input  logic [VW-1:0]     old_dest,
  input  logic [NLANES-1:0] exc_lane,
  input  logic [NLANES-1:0] fault_lane,
  output logic              out_valid,
  output logic [VW-1:0]     dest_out,
  output logic [NLANES-1:0] byte_we,
  output logic              exc_flag,
  output logic              fault_flag,
  output logic              illegal_mode
);
  // ---------------- next-state ----------------
  logic [MASK_W-1:0] mask_eff;
  logic [NLANES-1:0] lane_act, lane_use, we_nxt;
  logic [VW-1:0]     dest_nxt;
  logic              ill_nxt, exc_nxt, flt_nxt, zero_en;

  always_comb begin
    mask_eff = (pred_sel == '0) ? '1 : mask_reg;
    ill_nxt  = zero_mode & (dest_is_mem | req_pred);
    lane_use = ill_nxt ? '0 : lane_act;
    zero_en  = zero_mode & ~ill_nxt;
    we_nxt   = dest_is_mem ? lane_use : '0;
    exc_nxt  = |(exc_lane & lane_use);
    flt_nxt  = |(fault_lane & lane_use);
  end

  vpw_lane_act #(.NLANES(NLANES), .MASK_W(MASK_W)) u_act (
    .esize    (esz_e'(esize)),
    .mask_eff (mask_eff),
    .lane_act (lane_act)
  );

  vpw_byte_sel #(.LW(LANE_W), .NLANES(NLANES)) u_sel (
    .result   (result),
    .old_dest (old_dest),
    .lane_use (lane_use),
    .zero_en  (zero_en),
    .dest_nxt (dest_nxt)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_out     <= '0;
      byte_we      <= '0;
      exc_flag     <= 1'b0;
      fault_flag   <= 1'b0;
      illegal_mode <= 1'b0;
    end else if (in_valid) begin
      dest_out     <= dest_nxt;
      byte_we      <= we_nxt;
      exc_flag     <= exc_nxt;
      fault_flag   <= flt_nxt;
      illegal_mode <= ill_nxt;
    end
  end

  // ---------------- assertions ----------------
  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r5_implicit_store_all: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred_sel == '0 && dest_is_mem && !zero_mode |=> byte_we == '1);

  a_r6_empty_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred_sel != '0 && mask_reg == '0 |=> !exc_flag && !fault_flag);

  a_r4_empty_mask_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && zero_mode && !dest_is_mem && !req_pred && pred_sel != '0
    && mask_reg == '0 |=> dest_out == '0);

  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal_mode |-> byte_we == '0 && !exc_flag && !fault_flag);

  a_r7_reg_dest_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dest_is_mem |=> byte_we == '0);
endmodule

// File: tb/tb_vec_pred_wb.sv
`timescale 1ns/1ps
module tb_vec_pred_wb;
  localparam int NL = 64;
  localparam int VW = 512;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, zero_mode, dest_is_mem, req_pred;
  logic [1:0] esize;
  logic [2:0] pred_sel;
  logic [NL-1:0] mask_reg, exc_lane, fault_lane;
  logic [VW-1:0] result, old_dest;
  logic out_valid, exc_flag, fault_flag, illegal_mode;
  logic [VW-1:0] dest_out;
  logic [NL-1:0] byte_we;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vec_pred_wb dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esize(esize),
    .pred_sel(pred_sel), .mask_reg(mask_reg), .zero_mode(zero_mode),
    .dest_is_mem(dest_is_mem), .req_pred(req_pred), .result(result),
    .old_dest(old_dest), .exc_lane(exc_lane), .fault_lane(fault_lane),
    .out_valid(out_valid), .dest_out(dest_out), .byte_we(byte_we),
    .exc_flag(exc_flag), .fault_flag(fault_flag), .illegal_mode(illegal_mode)
  );

  // expected values, from the requirements
  logic [VW-1:0] e_dest;
  logic [NL-1:0] e_we;
  logic e_exc, e_flt, e_ill;

  task automatic chk(input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] rnd512();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic model();
    int bytes;
    logic act;
    bytes = 1 << esize;
    e_ill = zero_mode & (dest_is_mem | req_pred);
    e_exc = 1'b0; e_flt = 1'b0;
    for (int b = 0; b < NL; b++) begin
      act = (pred_sel == 3'd0) ? 1'b1 : mask_reg[b / bytes];
      if (e_ill) act = 1'b0;
      e_we[b] = dest_is_mem & act;
      if (act) begin
        e_dest[b*8 +: 8] = result[b*8 +: 8];
        e_exc |= exc_lane[b];
        e_flt |= fault_lane[b];
      end else if (zero_mode && !e_ill) e_dest[b*8 +: 8] = 8'h00;
      else e_dest[b*8 +: 8] = old_dest[b*8 +: 8];
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] es, input logic [2:0] ps,
                        input logic [NL-1:0] m, input logic zm, input logic mem,
                        input logic rp, input logic [NL-1:0] ex, input logic [NL-1:0] ft);
    @(negedge clk);
    esize = es; pred_sel = ps; mask_reg = m; zero_mode = zm;
    dest_is_mem = mem; req_pred = rp; exc_lane = ex; fault_lane = ft;
    result = rnd512(); old_dest = rnd512();
    in_valid = 1'b1;
    model();
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid (R1)", VW'(out_valid), VW'(1'b1));
    chk(req, "dest_out", dest_out, e_dest);
    chk(req, "byte_we", VW'(byte_we), VW'(e_we));
    chk(req, "exc_flag", VW'(exc_flag), VW'(e_exc));
    chk(req, "fault_flag", VW'(fault_flag), VW'(e_flt));
    chk(req, "illegal_mode", VW'(illegal_mode), VW'(e_ill));
  endtask

  task automatic t_reset();
    chk("R9", "out_valid", VW'(out_valid), '0);
    chk("R9", "dest_out", dest_out, '0);
    chk("R9", "byte_we", VW'(byte_we), '0);
    chk("R9", "flags", VW'({exc_flag, fault_flag, illegal_mode}), '0);
  endtask

  task automatic t_sizes_merge();  // R2 R3
    run_op("R2/R3 b8",  2'd0, 3'd1, 64'hA5C3_0FF0_1234_8001, 0, 0, 0, '0, '0);
    run_op("R2/R3 b16", 2'd1, 3'd2, 64'h0000_0000_9E37_79B9, 0, 0, 0, '0, '0);
    run_op("R2/R3 b32", 2'd2, 3'd3, 64'h0000_0000_0000_6B2D, 0, 0, 0, '0, '0);
    // R2: only bits 7:0 matter at 64-bit elements
    run_op("R2 b64 high bits", 2'd3, 3'd4, 64'hFFFF_FFFF_FFFF_FF5A, 0, 0, 0, '0, '0);
  endtask

  task automatic t_zero();  // R4
    run_op("R4 b8",  2'd0, 3'd5, 64'h0F0F_F0F0_3C3C_C3C3, 1, 0, 0, '0, '0);
    run_op("R4 b64", 2'd3, 3'd6, 64'h0000_0000_0000_0096, 1, 0, 0, '0, '0);
    run_op("R4 empty", 2'd2, 3'd7, 64'h0, 1, 0, 0, '0, '0);
  endtask

  task automatic t_implicit();  // R5
    run_op("R5 zero mask ignored", 2'd1, 3'd0, 64'h0, 1, 0, 0, '0, '0);
    run_op("R5 store", 2'd0, 3'd0, 64'h0, 0, 1, 0, '0, '0);
  endtask

  task automatic t_flags();  // R6 R7
    // flags only on masked-off element 1 (lanes 4..7 at 32-bit): expect quiet
    run_op("R6 masked flag", 2'd2, 3'd1, 64'h0000_0000_0000_FFFD, 0, 1, 0,
           64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0010);
    run_op("R6 active flag", 2'd2, 3'd1, 64'h0000_0000_0000_0002, 0, 1, 0,
           64'h0000_0000_0000_0040, 64'h0000_0000_0000_0080);
    run_op("R7 store b16", 2'd1, 3'd2, 64'h0000_0000_8421_1248, 0, 1, 0,
           64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF);
  endtask

  task automatic t_illegal();  // R8
    run_op("R8 zero to mem", 2'd0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, '1, '1);
    run_op("R8 zero req pred", 2'd3, 3'd2, 64'h0000_0000_0000_00FF, 1, 0, 1, '1, '1);
    run_op("R8 merge req pred ok", 2'd3, 3'd2, 64'h0000_0000_0000_0033, 0, 0, 1, '1, '0);
  endtask

  task automatic t_hold();  // R1
    logic [VW-1:0] d; logic [NL-1:0] w; logic [2:0] f;
    run_op("R1 base", 2'd0, 3'd3, 64'h1357_9BDF_2468_ACE0, 0, 1, 0, 64'h1, 64'h2);
    d = dest_out; w = byte_we; f = {exc_flag, fault_flag, illegal_mode};
    result = rnd512(); old_dest = rnd512(); mask_reg = ~mask_reg; zero_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "out_valid idle", VW'(out_valid), '0);
    chk("R1", "dest_out hold", dest_out, d);
    chk("R1", "byte_we hold", VW'(byte_we), VW'(w));
    chk("R1", "flags hold", VW'({exc_flag, fault_flag, illegal_mode}), VW'(f));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; esize = '0; pred_sel = '0; mask_reg = '0;
    zero_mode = 1'b0; dest_is_mem = 1'b0; req_pred = 1'b0;
    result = '0; old_dest = '0; exc_lane = '0; fault_lane = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sizes_merge();
    t_zero();
    t_implicit();
    t_flags();
    t_illegal();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule